// File: doc/BRIEF.md
# Round-robin wavefront issue scheduler

This block is the instruction issue stage of a compute unit built from four vector SIMD units of 16 lanes each. A SIMD executes one 64-item wavefront instruction as four lane-group passes of 16 items, one pass per cycle. The scheduler gives each SIMD exactly one issue opportunity every fourth cycle. A free-running rotation counter selects the SIMD that is eligible in the current cycle.

Every SIMD keeps a pool of up to ten resident wavefronts. Wave allocation and retire requests fill and empty the pool. A per-wave ready flag tells the scheduler which waves have an instruction waiting. In its turn, a SIMD issues its oldest ready wave, where age is the order of allocation. The block then steps that SIMD's lane-group counter through the four passes. Instruction decode, register storage and the arithmetic datapath lie outside the block.

Top module: `wave_issue_sched`

## Requirements
- R1: While reset is asserted and after it is released, no wave is resident, the eligible SIMD is 0, `issue_valid` is low and every SIMD is idle with a lane-group count of 0.
- R2: The eligible SIMD shown on `issue_simd` steps 0,1,2,3,0,... once per cycle after reset. An issue only goes to the SIMD whose turn it is.
- R3: An issue names a wave that is resident and ready in the eligible SIMD. If that SIMD has no ready wave, `issue_valid` stays low for that cycle.
- R4: Among the ready waves of the eligible SIMD, the one allocated earliest wins, whatever its slot number.
- R5: An accepted allocation takes the lowest-numbered free slot of the SIMD named by `alloc_simd`. That slot appears on `alloc_slot` in the request cycle, and the wave is resident from the next cycle.
- R6: An allocation to a SIMD that already holds ten waves raises `alloc_stall` in the same cycle and changes no resident state.
- R7: A retire request clears the named slot from the next cycle on. The slot is then reusable, and the wave in it counts as the youngest.
- R8: An issue starts that SIMD's lane-group counter. The counter reads 0,1,2,3 on the four following cycles, and `simd_busy` is high during those cycles. With no further issue, the SIMD then returns to idle with a count of 0.
- R9: A SIMD accepts a new issue only when it is idle or on lane-group pass 3, so a SIMD with a ready wave issues back to back every fourth cycle.
- R10: The SIMDs are independent. A full pool or ready waves in one SIMD do not change allocation or issue in another. Ready bit `s*10+w` belongs to SIMD s, slot w, and the same index is used in `resident_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Wave allocation request |
| alloc_simd | input | 2 | Target SIMD of the allocation |
| alloc_stall | output | 1 | Allocation refused because the pool is full |
| alloc_slot | output | 4 | Slot the allocation takes |
| retire_valid | input | 1 | Wave retire request |
| retire_simd | input | 2 | SIMD of the retiring wave |
| retire_slot | input | 4 | Slot of the retiring wave |
| wave_ready | input | 40 | Per-wave ready flags, bit s*10+w |
| issue_valid | output | 1 | Issue strobe |
| issue_simd | output | 2 | Eligible SIMD this cycle, which is the issue target |
| issue_slot | output | 4 | Slot of the issued wave |
| lane_grp | output | 8 | Lane-group pass count, 2 bits per SIMD |
| simd_busy | output | 4 | SIMD is executing lane-group passes |
| resident_mask | output | 40 | Resident waves, bit s*10+w |

## Verification
The oldest-first choice is the case that is hardest to reach from the ports. Slot order and allocation order only differ after a wave retires and a new wave refills a low slot. The stimulus therefore fills SIMD 0, retires slot 3 and reallocates it, which makes slot 3 the youngest. A table of ready patterns then checks the winner in each turn of SIMD 0, including a pattern that holds both slot 3 and a higher slot. Directed sequences line up a ready wave with the rotation so that the back-to-back issue on pass 3 and the return to idle are each observed.

// File: rtl/wis_pkg.sv
package wis_pkg;
  // Step a counter that wraps to zero at lim-1.
  function automatic int unsigned wrap_next(input int unsigned v, input int unsigned lim);
    return (v == lim - 1) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/wave_slot_pool.sv
module wave_slot_pool #(
  parameter int SLOTS  = 10,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              retire_en,
  input  logic [SLOT_W-1:0] retire_slot,
  input  logic [SLOTS-1:0]  ready,
  output logic [SLOTS-1:0]  resident,
  output logic              full,
  output logic [SLOT_W-1:0] free_slot,
  output logic              pick_valid,
  output logic [SLOT_W-1:0] pick_slot
);
  // older[i][j] set: wave in slot i was allocated before wave in slot j
  logic [SLOTS-1:0] older [SLOTS];
  logic [SLOTS-1:0] cand;
  logic             alloc_take;

  function automatic logic [SLOT_W-1:0] first_free(input logic [SLOTS-1:0] m);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!m[i]) r = SLOT_W'(i);
    return r;
  endfunction

  assign full       = &resident;
  assign free_slot  = first_free(resident);
  assign alloc_take = alloc_en && !full;
  assign cand       = resident & ready;

  always_comb begin
    pick_valid = 1'b0;
    pick_slot  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < SLOTS; j++)
        if (j != i && cand[j] && older[j][i]) blocked = 1'b1;
      if (cand[i] && !blocked && !pick_valid) begin
        pick_valid = 1'b1;
        pick_slot  = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resident <= '0;
      for (int i = 0; i < SLOTS; i++) older[i] <= '0;
    end else begin
      if (retire_en) resident[retire_slot] <= 1'b0;
      if (alloc_take) begin
        resident[free_slot] <= 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
          if (SLOT_W'(i) == free_slot) older[i] <= '0;
          else older[i][free_slot] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/simd_lane_seq.sv
module simd_lane_seq
  import wis_pkg::*;
#(
  parameter int PASSES = 4,
  parameter int PW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [PW-1:0] lane,
  output logic          accept
);
  logic last_pass;
  assign last_pass = (lane == PW'(PASSES - 1));
  assign accept    = !busy || last_pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      lane <= '0;
    end else if (start) begin
      busy <= 1'b1;
      lane <= '0;
    end else if (busy) begin
      busy <= !last_pass;
      lane <= PW'(wrap_next(int'(lane), PASSES));
    end
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_SIMD   = 4,
  parameter int SLOTS      = 10,
  parameter int LANES      = 16,
  parameter int WAVE_ITEMS = 64,
  localparam int RR_W   = $clog2(NUM_SIMD),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PASSES = WAVE_ITEMS / LANES,
  localparam int PW     = $clog2(PASSES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [RR_W-1:0]           alloc_simd,
  output logic                      alloc_stall,
  output logic [SLOT_W-1:0]         alloc_slot,
  input  logic                      retire_valid,
  input  logic [RR_W-1:0]           retire_simd,
  input  logic [SLOT_W-1:0]         retire_slot,
  input  logic [NUM_SIMD*SLOTS-1:0] wave_ready,
  output logic                      issue_valid,
  output logic [RR_W-1:0]           issue_simd,
  output logic [SLOT_W-1:0]         issue_slot,
  output logic [NUM_SIMD*PW-1:0]    lane_grp,
  output logic [NUM_SIMD-1:0]       simd_busy,
  output logic [NUM_SIMD*SLOTS-1:0] resident_mask
);
  logic [RR_W-1:0]   rr_q;
  logic [NUM_SIMD-1:0] pool_full, pick_valid, simd_accept, simd_start;
  logic [SLOT_W-1:0] free_slot [NUM_SIMD];
  logic [SLOT_W-1:0] pick_slot [NUM_SIMD];

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= RR_W'(wrap_next(int'(rr_q), NUM_SIMD));
  end

  for (genvar k = 0; k < NUM_SIMD; k++) begin : g_simd
    logic turn;
    assign turn          = (rr_q == RR_W'(k));
    assign simd_start[k] = turn && pick_valid[k] && simd_accept[k];

    wave_slot_pool #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) pool_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (alloc_valid && alloc_simd == RR_W'(k)),
      .retire_en  (retire_valid && retire_simd == RR_W'(k)),
      .retire_slot(retire_slot),
      .ready      (wave_ready[k*SLOTS +: SLOTS]),
      .resident   (resident_mask[k*SLOTS +: SLOTS]),
      .full       (pool_full[k]),
      .free_slot  (free_slot[k]),
      .pick_valid (pick_valid[k]),
      .pick_slot  (pick_slot[k])
    );

    simd_lane_seq #(.PASSES(PASSES), .PW(PW)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (simd_start[k]),
      .busy  (simd_busy[k]),
      .lane  (lane_grp[k*PW +: PW]),
      .accept(simd_accept[k])
    );
  end

  assign alloc_stall = alloc_valid && pool_full[alloc_simd];
  assign alloc_slot  = free_slot[alloc_simd];
  assign issue_valid = |simd_start;
  assign issue_simd  = rr_q;
  assign issue_slot  = pick_slot[rr_q];
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 10,
  parameter int RR_W     = 2,
  parameter int SLOT_W   = 4,
  parameter int PASSES   = 4,
  parameter int PW       = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      alloc_valid,
  input logic [RR_W-1:0]           alloc_simd,
  input logic                      alloc_stall,
  input logic [SLOT_W-1:0]         alloc_slot,
  input logic [NUM_SIMD*SLOTS-1:0] wave_ready,
  input logic                      issue_valid,
  input logic [RR_W-1:0]           issue_simd,
  input logic [SLOT_W-1:0]         issue_slot,
  input logic [NUM_SIMD*PW-1:0]    lane_grp,
  input logic [NUM_SIMD-1:0]       simd_busy,
  input logic [NUM_SIMD*SLOTS-1:0] resident_mask,
  input logic [NUM_SIMD-1:0]       simd_start
);
  int unsigned issue_idx, alloc_idx;
  assign issue_idx = int'(issue_simd) * SLOTS + int'(issue_slot);
  assign alloc_idx = int'(alloc_simd) * SLOTS + int'(alloc_slot);

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (issue_simd == (($past(issue_simd) == RR_W'(NUM_SIMD - 1)) ? '0 : $past(issue_simd) + 1'b1))); // R2

  AST_ISSUE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(simd_start)); // R2

  AST_ISSUE_READY_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (resident_mask[issue_idx] && wave_ready[issue_idx])); // R3

  AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |-> (alloc_valid && (&resident_mask[int'(alloc_simd)*SLOTS +: SLOTS]))); // R6

  AST_ALLOC_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_stall) |=> resident_mask[$past(alloc_idx)]); // R5

  for (genvar k = 0; k < NUM_SIMD; k++) begin : g_chk
    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (simd_busy[k] && lane_grp[k*PW +: PW] != PW'(PASSES - 1))
        |=> (simd_busy[k] && lane_grp[k*PW +: PW] == $past(lane_grp[k*PW +: PW]) + 1'b1)); // R8

    AST_NO_EARLY_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_simd == RR_W'(k))
        |-> (!simd_busy[k] || lane_grp[k*PW +: PW] == PW'(PASSES - 1))); // R9
  end
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
  .NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS), .RR_W(RR_W),
  .SLOT_W(SLOT_W), .PASSES(PASSES), .PW(PW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_simd   (alloc_simd),
  .alloc_stall  (alloc_stall),
  .alloc_slot   (alloc_slot),
  .wave_ready   (wave_ready),
  .issue_valid  (issue_valid),
  .issue_simd   (issue_simd),
  .issue_slot   (issue_slot),
  .lane_grp     (lane_grp),
  .simd_busy    (simd_busy),
  .resident_mask(resident_mask),
  .simd_start   (simd_start)
);

// File: tb/wave_issue_sched_tb_top.sv
module wave_issue_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_simd = '0;
  logic        alloc_stall;
  logic [3:0]  alloc_slot;
  logic        retire_valid = 1'b0;
  logic [1:0]  retire_simd = '0;
  logic [3:0]  retire_slot = '0;
  logic [39:0] wave_ready = '0;
  logic        issue_valid;
  logic [1:0]  issue_simd;
  logic [3:0]  issue_slot;
  logic [7:0]  lane_grp;
  logic [3:0]  simd_busy;
  logic [39:0] resident_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [1:0] turn_m = '0; // bench's own rotation model

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) turn_m <= 2'd0;
    else        turn_m <= turn_m + 2'd1;
  end

  wave_issue_sched dut_i (.*);

  // {ready pattern for SIMD 0, expect issue, expected slot}
  localparam logic [14:0] VEC [6] = '{
    {10'b10_0000_1000, 1'b1, 4'd9},
    {10'b00_0000_1010, 1'b1, 4'd1},
    {10'b00_0000_1000, 1'b1, 4'd3},
    {10'b00_0000_0000, 1'b0, 4'd0},
    {10'b01_1000_1000, 1'b1, 4'd7},
    {10'b11_1111_1111, 1'b1, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_turn(input logic [1:0] k);
    do @(negedge clk); while (turn_m != k);
  endtask

  task automatic do_alloc(input logic [1:0] s, input int exp_slot, input bit exp_stall, input string req);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_simd  = s;
    #1;
    chk(alloc_stall == exp_stall, {req, " stall"}, alloc_stall, exp_stall);
    if (!exp_stall) chk(alloc_slot == exp_slot, {req, " slot"}, alloc_slot, exp_slot);
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_retire(input logic [1:0] s, input logic [3:0] w);
    @(negedge clk);
    retire_valid = 1'b1;
    retire_simd  = s;
    retire_slot  = w;
    @(posedge clk); #1;
    retire_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(issue_valid == 1'b0, "R1 issue_valid", issue_valid, 0);
    chk(resident_mask == '0, "R1 resident", int'(resident_mask[31:0]), 0);
    chk(simd_busy == '0 && lane_grp == '0, "R1 idle", simd_busy, 0);
    chk(issue_simd == 2'd0, "R1 rr", issue_simd, 0);
    rst_n = 1'b1;

    // R2: rotation
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(issue_simd == turn_m, "R2 rotation", issue_simd, turn_m);
      chk(issue_valid == 1'b0, "R3 idle without ready", issue_valid, 0);
    end

    // R5: fill SIMD 0 in slot order
    for (int i = 0; i < 10; i++) do_alloc(2'd0, i, 1'b0, "R5 alloc");
    @(negedge clk);
    chk(resident_mask[9:0] == 10'h3FF, "R5 resident", resident_mask[9:0], 10'h3FF);
    // R6: full pool refuses
    do_alloc(2'd0, 0, 1'b1, "R6 full");
    @(negedge clk);
    chk(resident_mask[39:10] == '0 && resident_mask[9:0] == 10'h3FF, "R6 unchanged",
        int'(resident_mask[31:0]), 32'h3FF);
    // R10: another SIMD still allocates
    do_alloc(2'd1, 0, 1'b0, "R10 other simd");

    // R7: retire slot 3, then reuse
    do_retire(2'd0, 4'd3);
    @(negedge clk);
    chk(resident_mask[3] == 1'b0, "R7 retired", resident_mask[3], 0);
    do_alloc(2'd0, 3, 1'b0, "R7 reuse");

    // R4: oldest-ready table (slot 3 is now youngest)
    for (int v = 0; v < 6; v++) begin
      wait_turn(2'd3);
      wave_ready[9:0] = VEC[v][14:5];
      wait_turn(2'd0);
      chk(issue_valid == VEC[v][4], "R4 issue valid", issue_valid, VEC[v][4]);
      if (VEC[v][4])
        chk(issue_slot == VEC[v][3:0], "R4 oldest slot", issue_slot, VEC[v][3:0]);
    end

    // R8/R9: lane-group passes and back-to-back issue
    wave_ready = '0;
    repeat (8) @(negedge clk);
    chk(simd_busy[0] == 1'b0, "R8 idle before", simd_busy[0], 0);
    wait_turn(2'd3);
    wave_ready[0] = 1'b1;
    wait_turn(2'd0);
    chk(issue_valid && issue_slot == 4'd0, "R8 issue", issue_valid, 1);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      chk(simd_busy[0] && lane_grp[1:0] == p[1:0], "R8 pass", lane_grp[1:0], p);
    end
    @(negedge clk);
    chk(lane_grp[1:0] == 2'd3 && issue_valid, "R9 issue on pass 3", lane_grp[1:0], 3);
    @(negedge clk);
    chk(simd_busy[0] && lane_grp[1:0] == 2'd0, "R9 restart", lane_grp[1:0], 0);
    wave_ready[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk(lane_grp[1:0] == 2'd3 && !issue_valid, "R3 no issue without ready", issue_valid, 0);
    @(negedge clk);
    chk(simd_busy[0] == 1'b0 && lane_grp[1:0] == 2'd0, "R8 back to idle", simd_busy[0], 0);

    // R10/R2: SIMD 2 issues only in its own turn
    do_alloc(2'd2, 0, 1'b0, "R10 alloc simd2");
    wave_ready[20] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(issue_valid == (turn_m == 2'd2), "R2 turn only", issue_valid, turn_m == 2'd2);
      if (turn_m == 2'd2)
        chk(issue_simd == 2'd2 && issue_slot == 4'd0, "R10 simd2 slot", issue_slot, 0);
    end

    // R7: retired wave is no longer issued
    wait_turn(2'd1);
    do_retire(2'd2, 4'd0);
    wait_turn(2'd2);
    chk(!issue_valid && !resident_mask[20], "R7 retired no issue", issue_valid, 0);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(resident_mask == '0 && issue_simd == 2'd0 && !issue_valid, "R1 mid reset",
        int'(resident_mask[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_simd == 2'd1 && simd_busy == '0, "R1 after release", issue_simd, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule